// File: doc/BRIEF.md
# Directory Home Node Controller

This block is the home-side coherence controller for one bank of a shared second-level cache. It holds one directory entry for each block in a small, fixed set of blocks, and all entries sit in registers. Each entry records a state (invalid, shared, exclusive clean or exclusive dirty), a vector with one bit per core for the sharers, the ID of the owning core, and the bank's own copy of the block data. Private first-level caches send it read and read-exclusive requests. For each request it sends a data reply to the requester, and where the entry calls for it, it also sends invalidations to the sharers or forwards the request to the current owner.

A read to a block that another core holds exclusively is handled in parallel. The bank's own data goes to the requester at once, and the request goes to the owner in the same cycle. The owner then closes the transaction with one of two completion messages. A clean confirmation means the bank's data was current. A dirty writeback carries the data, and the controller stores it as its own copy. A read-exclusive request to a shared block invalidates every other sharer. The data reply tells the requester how many invalidation acknowledgements it must collect. Those acknowledgements are also sent back to the home node, so that it knows when the block is settled.

While a block waits for acknowledgements or for an owner's message, the block is busy. A request to a busy block is held off by keeping the request ready low. All message channels use valid/ready handshakes.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is invalid, and the bank copy of block b equals the low DW bits of (0xA5 XOR 19*b). `req_ready` is 1, and no outgoing channel is valid.
- R2: A request (req_excl 0 = read, 1 = read-exclusive) to an invalid block gets a reply with rsp_excl=1, rsp_acks=0 and rsp_owner_pending=0. The requester becomes the owner: exclusive clean after a read, exclusive dirty after a read-exclusive.
- R3: A read to a shared block gets a non-exclusive reply with no forward and no invalidation, and the requester is added to the sharers.
- R4: A read to a block owned exclusively by another core sends two messages in the cycle after acceptance. The first is a reply with the bank data and rsp_owner_pending=1. The second is a forward to the owner with fwd_excl=0 and fwd_req = the requester. The block then becomes shared by the owner and the requester.
- R5: The owner's completion message decides the bank copy. A dirty writeback (cin_kind=2) replaces the bank copy with cin_data. A clean confirmation (cin_kind=1) leaves the bank copy unchanged. Either message ends the busy period.
- R6: A read-exclusive to a shared block sends exactly one invalidation to each sharer other than the requester. The reply has rsp_excl=1 and rsp_acks equal to the number of invalidations. The requester becomes the exclusive-dirty owner, and it is the only sharer.
- R7: A block stays busy until all of its invalidation acknowledgements (cin_kind=0) or its owner message have arrived. While it is busy, a request to it sees req_ready=0. req_ready returns to 1 one cycle after the last completion message.
- R8: A read-exclusive to a block owned exclusively by another core sends two messages. The reply has rsp_excl=1 and rsp_owner_pending=1, and the forward to the owner has fwd_excl=1. The requester becomes the exclusive-dirty owner.
- R9: A request from the block's current exclusive owner gets a reply with rsp_excl=1, and no forward or invalidation is sent. A read-exclusive from the owner leaves the block exclusive dirty.
- R10: The reply is valid in the first cycle after acceptance, and it holds its fields stable until it is taken. Invalidations go out one per handshake, in ascending core index.
- R11: A completion message for a block that is not waiting for one is ignored, and the bank copy of that block is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (controller idle and target block not busy) |
| req_excl | input | 1 | 0 = read, 1 = read-exclusive |
| req_src | input | IDW | Requesting core |
| req_blk | input | BLKW | Target block index |
| rsp_valid | output | 1 | Data reply offered |
| rsp_ready | input | 1 | Data reply taken |
| rsp_dst | output | IDW | Core receiving the reply |
| rsp_blk | output | BLKW | Block of the reply |
| rsp_data | output | DW | Bank copy of the block |
| rsp_acks | output | CNTW | Invalidation acknowledgements the requester must collect |
| rsp_excl | output | 1 | Requester holds the block exclusively |
| rsp_owner_pending | output | 1 | Requester must wait for a message from the previous owner |
| inv_valid | output | 1 | Invalidation offered |
| inv_ready | input | 1 | Invalidation taken |
| inv_dst | output | IDW | Core to invalidate |
| inv_blk | output | BLKW | Block to invalidate |
| fwd_valid | output | 1 | Forward to owner offered |
| fwd_ready | input | 1 | Forward taken |
| fwd_dst | output | IDW | Current owner |
| fwd_req | output | IDW | Core the owner must answer |
| fwd_blk | output | BLKW | Forwarded block |
| fwd_excl | output | 1 | Owner must give up its copy |
| cin_valid | input | 1 | Completion message from a first-level cache |
| cin_ready | output | 1 | Completion message accepted (always 1) |
| cin_kind | input | 2 | 0 = invalidation acknowledgement, 1 = owner clean, 2 = owner dirty with data |
| cin_blk | input | BLKW | Block the completion refers to |
| cin_data | input | DW | Writeback data for cin_kind 2 |

## Verification
The reply, and any forward, is due in the first cycle after the rising edge that accepts the request. The bench samples on the falling edge right after acceptance, checks for both messages there, and only then starts driving random ready patterns. Invalidations arrive one per handshake. The bench collects them over a fixed window whose ready signals are forced high in the second half, so that every expected message has arrived before the window closes. After the completion message that clears a busy block, the bench expects req_ready to return one cycle later. Before that message it expects req_ready held low for a request to the same block.

// File: rtl/hd_pkg.sv
package hd_pkg;

  typedef enum logic [1:0] {
    DS_INV = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2,
    DS_DRT = 2'd3
  } dstate_e;

  localparam logic [1:0] CK_IACK   = 2'd0;
  localparam logic [1:0] CK_OCLEAN = 2'd1;
  localparam logic [1:0] CK_ODIRTY = 2'd2;

  function automatic int unsigned bit_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += 32'(v[i]);
    return n;
  endfunction

  function automatic int unsigned low_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 32'(i);
    return r;
  endfunction

  function automatic logic [31:0] block_seed(input int unsigned b);
    return 32'hA5 ^ (b * 32'd19);
  endfunction

endpackage

// File: rtl/hd_entry.sv
module hd_entry
  import hd_pkg::*;
#(
  parameter int NC = 4,
  parameter int DW = 8,
  parameter int IDW = 2,
  parameter int CNTW = 3,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  dstate_e         upd_st,
  input  logic [NC-1:0]   upd_sh,
  input  logic [IDW-1:0]  upd_own,
  input  logic            upd_wait,
  input  logic [CNTW-1:0] upd_cnt,
  input  logic            cin_hit,
  input  logic [1:0]      cin_kind,
  input  logic [DW-1:0]   cin_data,
  output dstate_e         st,
  output logic [NC-1:0]   sh,
  output logic [IDW-1:0]  own,
  output logic            busy,
  output logic [DW-1:0]   data
);

  logic            wait_own;
  logic [CNTW-1:0] cnt;

  // named events for the checks
  logic ack_take, own_take, wb_take;
  assign ack_take = cin_hit && (cin_kind == CK_IACK) && (cnt != '0);
  assign own_take = cin_hit && wait_own &&
                    ((cin_kind == CK_OCLEAN) || (cin_kind == CK_ODIRTY));
  assign wb_take  = own_take && (cin_kind == CK_ODIRTY);
  assign busy     = wait_own || (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= DS_INV;
      sh       <= '0;
      own      <= '0;
      wait_own <= 1'b0;
      cnt      <= '0;
      data     <= INIT;
    end else if (upd_en) begin
      st       <= upd_st;
      sh       <= upd_sh;
      own      <= upd_own;
      wait_own <= upd_wait;
      cnt      <= upd_cnt;
    end else begin
      if (ack_take) cnt <= cnt - 1'b1;
      if (own_take) wait_own <= 1'b0;
      if (wb_take)  data <= cin_data;
    end
  end

  // R7
  upd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> !busy);

  // R5
  busy_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_own && (cnt != '0)));

  // R11
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !upd_en) |=> $stable(data));

endmodule

// File: rtl/hd_issue.sv
module hd_issue
  import hd_pkg::*;
#(
  parameter int NC = 4,
  parameter int DW = 8,
  parameter int IDW = 2,
  parameter int BLKW = 2,
  parameter int CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IDW-1:0]  ld_dst,
  input  logic [BLKW-1:0] ld_blk,
  input  logic [DW-1:0]   ld_data,
  input  logic [CNTW-1:0] ld_acks,
  input  logic            ld_excl,
  input  logic            ld_fwd,
  input  logic [IDW-1:0]  ld_fwd_dst,
  input  logic            ld_fwd_excl,
  input  logic [NC-1:0]   ld_inv,
  input  logic            rsp_ready,
  input  logic            fwd_ready,
  input  logic            inv_ready,
  output logic            rsp_valid,
  output logic [IDW-1:0]  rsp_dst,
  output logic [BLKW-1:0] rsp_blk,
  output logic [DW-1:0]   rsp_data,
  output logic [CNTW-1:0] rsp_acks,
  output logic            rsp_excl,
  output logic            rsp_owner_pending,
  output logic            fwd_valid,
  output logic [IDW-1:0]  fwd_dst,
  output logic [IDW-1:0]  fwd_req,
  output logic [BLKW-1:0] fwd_blk,
  output logic            fwd_excl,
  output logic            inv_valid,
  output logic [IDW-1:0]  inv_dst,
  output logic [BLKW-1:0] inv_blk,
  output logic [NC-1:0]   inv_left,
  output logic            idle
);

  logic rsp_pend, fwd_pend;

  assign rsp_valid = rsp_pend;
  assign fwd_valid = fwd_pend;
  assign inv_valid = (inv_left != '0);
  assign inv_dst   = IDW'(low_index(32'(inv_left)));
  assign fwd_req   = rsp_dst;
  assign fwd_blk   = rsp_blk;
  assign inv_blk   = rsp_blk;
  assign idle      = !rsp_pend && !fwd_pend && !inv_valid;

  logic rsp_fire, fwd_fire, inv_fire;
  assign rsp_fire = rsp_valid && rsp_ready;
  assign fwd_fire = fwd_valid && fwd_ready;
  assign inv_fire = inv_valid && inv_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_pend          <= 1'b0;
      fwd_pend          <= 1'b0;
      inv_left          <= '0;
      rsp_dst           <= '0;
      rsp_blk           <= '0;
      rsp_data          <= '0;
      rsp_acks          <= '0;
      rsp_excl          <= 1'b0;
      rsp_owner_pending <= 1'b0;
      fwd_dst           <= '0;
      fwd_excl          <= 1'b0;
    end else if (load) begin
      rsp_pend          <= 1'b1;
      fwd_pend          <= ld_fwd;
      inv_left          <= ld_inv;
      rsp_dst           <= ld_dst;
      rsp_blk           <= ld_blk;
      rsp_data          <= ld_data;
      rsp_acks          <= ld_acks;
      rsp_excl          <= ld_excl;
      rsp_owner_pending <= ld_fwd;
      fwd_dst           <= ld_fwd_dst;
      fwd_excl          <= ld_fwd_excl;
    end else begin
      if (rsp_fire) rsp_pend <= 1'b0;
      if (fwd_fire) fwd_pend <= 1'b0;
      if (inv_fire) inv_left <= inv_left & ~(NC'(1) << inv_dst);
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_acks) && $stable(rsp_dst)));

  // R10
  inv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |=> (!inv_valid || (inv_dst > $past(inv_dst))));

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hd_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int NBLOCKS = 4,
  parameter int DW      = 8,
  localparam int IDW  = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int BLKW = (NBLOCKS > 1) ? $clog2(NBLOCKS) : 1,
  localparam int CNTW = $clog2(NCORES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_excl,
  input  logic [IDW-1:0]  req_src,
  input  logic [BLKW-1:0] req_blk,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [IDW-1:0]  rsp_dst,
  output logic [BLKW-1:0] rsp_blk,
  output logic [DW-1:0]   rsp_data,
  output logic [CNTW-1:0] rsp_acks,
  output logic            rsp_excl,
  output logic            rsp_owner_pending,
  output logic            inv_valid,
  input  logic            inv_ready,
  output logic [IDW-1:0]  inv_dst,
  output logic [BLKW-1:0] inv_blk,
  output logic            fwd_valid,
  input  logic            fwd_ready,
  output logic [IDW-1:0]  fwd_dst,
  output logic [IDW-1:0]  fwd_req,
  output logic [BLKW-1:0] fwd_blk,
  output logic            fwd_excl,
  input  logic            cin_valid,
  output logic            cin_ready,
  input  logic [1:0]      cin_kind,
  input  logic [BLKW-1:0] cin_blk,
  input  logic [DW-1:0]   cin_data
);

  dstate_e         e_st   [NBLOCKS];
  logic [NCORES-1:0] e_sh [NBLOCKS];
  logic [IDW-1:0]  e_own  [NBLOCKS];
  logic [DW-1:0]   e_data [NBLOCKS];
  logic [NBLOCKS-1:0] busy_vec;

  logic              issue_idle, acc;
  logic [NCORES-1:0] inv_left;

  // decision outputs
  dstate_e           n_st;
  logic [NCORES-1:0] n_sh, d_inv, src_bit;
  logic [IDW-1:0]    n_own;
  logic              n_wait, d_excl, d_fwd, d_fexcl;
  logic [CNTW-1:0]   n_cnt;

  assign cin_ready = 1'b1;
  assign req_ready = issue_idle && !busy_vec[req_blk];
  assign acc       = req_valid && req_ready;
  assign src_bit   = NCORES'(1) << req_src;

  always_comb begin
    n_st    = e_st[req_blk];
    n_sh    = e_sh[req_blk];
    n_own   = e_own[req_blk];
    n_wait  = 1'b0;
    n_cnt   = '0;
    d_excl  = 1'b0;
    d_fwd   = 1'b0;
    d_fexcl = 1'b0;
    d_inv   = '0;
    case (e_st[req_blk])
      DS_INV: begin
        d_excl = 1'b1;
        n_own  = req_src;
        n_sh   = src_bit;
        n_st   = req_excl ? DS_DRT : DS_EXC;
      end
      DS_SHR: begin
        if (!req_excl) begin
          n_sh = e_sh[req_blk] | src_bit;
        end else begin
          d_inv  = e_sh[req_blk] & ~src_bit;
          n_cnt  = CNTW'(bit_count(32'(d_inv)));
          d_excl = 1'b1;
          n_st   = DS_DRT;
          n_own  = req_src;
          n_sh   = src_bit;
        end
      end
      default: begin
        if (e_own[req_blk] == req_src) begin
          d_excl = 1'b1;
          if (req_excl) n_st = DS_DRT;
        end else begin
          d_fwd   = 1'b1;
          d_fexcl = req_excl;
          n_wait  = 1'b1;
          if (req_excl) begin
            d_excl = 1'b1;
            n_st   = DS_DRT;
            n_own  = req_src;
            n_sh   = src_bit;
          end else begin
            n_st = DS_SHR;
            n_sh = src_bit | (NCORES'(1) << e_own[req_blk]);
          end
        end
      end
    endcase
  end

  for (genvar b = 0; b < NBLOCKS; b++) begin : g_ent
    hd_entry #(
      .NC(NCORES), .DW(DW), .IDW(IDW), .CNTW(CNTW),
      .INIT(DW'(block_seed(b)))
    ) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (acc && (req_blk == BLKW'(b))),
      .upd_st   (n_st),
      .upd_sh   (n_sh),
      .upd_own  (n_own),
      .upd_wait (n_wait),
      .upd_cnt  (n_cnt),
      .cin_hit  (cin_valid && (cin_blk == BLKW'(b))),
      .cin_kind (cin_kind),
      .cin_data (cin_data),
      .st       (e_st[b]),
      .sh       (e_sh[b]),
      .own      (e_own[b]),
      .busy     (busy_vec[b]),
      .data     (e_data[b])
    );
  end

  hd_issue #(
    .NC(NCORES), .DW(DW), .IDW(IDW), .BLKW(BLKW), .CNTW(CNTW)
  ) u_issue (
    .clk               (clk),
    .rst_n             (rst_n),
    .load              (acc),
    .ld_dst            (req_src),
    .ld_blk            (req_blk),
    .ld_data           (e_data[req_blk]),
    .ld_acks           (n_cnt),
    .ld_excl           (d_excl),
    .ld_fwd            (d_fwd),
    .ld_fwd_dst        (e_own[req_blk]),
    .ld_fwd_excl       (d_fexcl),
    .ld_inv            (d_inv),
    .rsp_ready         (rsp_ready),
    .fwd_ready         (fwd_ready),
    .inv_ready         (inv_ready),
    .rsp_valid         (rsp_valid),
    .rsp_dst           (rsp_dst),
    .rsp_blk           (rsp_blk),
    .rsp_data          (rsp_data),
    .rsp_acks          (rsp_acks),
    .rsp_excl          (rsp_excl),
    .rsp_owner_pending (rsp_owner_pending),
    .fwd_valid         (fwd_valid),
    .fwd_dst           (fwd_dst),
    .fwd_req           (fwd_req),
    .fwd_blk           (fwd_blk),
    .fwd_excl          (fwd_excl),
    .inv_valid         (inv_valid),
    .inv_dst           (inv_dst),
    .inv_blk           (inv_blk),
    .inv_left          (inv_left),
    .idle              (issue_idle)
  );

  // R4
  fwd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && d_fwd) |=> (fwd_valid && rsp_valid && rsp_owner_pending));

  // R6
  ack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_acks == CNTW'($countones(inv_left))));

  // R10
  rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

endmodule

// File: tb/home_dir_ctrl_tb.sv
module home_dir_ctrl_tb;

  localparam int NC = 4;
  localparam int NB = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_excl = 0;
  logic [1:0] req_src = 0, req_blk = 0;
  logic req_ready;
  logic rsp_valid, rsp_ready = 0;
  logic [1:0] rsp_dst, rsp_blk;
  logic [7:0] rsp_data;
  logic [2:0] rsp_acks;
  logic rsp_excl, rsp_owner_pending;
  logic inv_valid, inv_ready = 0;
  logic [1:0] inv_dst, inv_blk;
  logic fwd_valid, fwd_ready = 0;
  logic [1:0] fwd_dst, fwd_req, fwd_blk;
  logic fwd_excl;
  logic cin_valid = 0, cin_ready;
  logic [1:0] cin_kind = 0, cin_blk = 0;
  logic [7:0] cin_data = 0;

  always #4 clk = ~clk;

  home_dir_ctrl #(.NCORES(NC), .NBLOCKS(NB), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_excl(req_excl),
    .req_src(req_src), .req_blk(req_blk),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dst(rsp_dst),
    .rsp_blk(rsp_blk), .rsp_data(rsp_data), .rsp_acks(rsp_acks),
    .rsp_excl(rsp_excl), .rsp_owner_pending(rsp_owner_pending),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_dst(inv_dst),
    .inv_blk(inv_blk),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_dst(fwd_dst),
    .fwd_req(fwd_req), .fwd_blk(fwd_blk), .fwd_excl(fwd_excl),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_kind(cin_kind),
    .cin_blk(cin_blk), .cin_data(cin_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model: state 0 invalid, 1 shared, 2 excl clean, 3 excl dirty
  int         m_st  [NB];
  logic [3:0] m_sh  [NB];
  int         m_own [NB];
  logic [7:0] m_dat [NB];
  logic [7:0] last_data;

  function automatic logic [7:0] seed_of(input int b);
    logic [7:0] p;
    p = 8'(b * 19);
    return 8'hA5 ^ p;
  endfunction

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic send_cin(input logic [1:0] k, input int blk, input logic [7:0] d);
    @(negedge clk);
    cin_valid = 1; cin_kind = k; cin_blk = 2'(blk); cin_data = d;
    @(negedge clk);
    cin_valid = 0;
  endtask

  task automatic probe_stall(input int blk);
    req_valid = 1; req_blk = 2'(blk); req_src = 2'($urandom % 4);
    req_excl = 1'($urandom % 2);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(req_ready == 0, "R7", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic txn(input bit ex, input int src, input int blk,
                     input bit dirty, input bit probe, input logic [7:0] wdat);
    int st = m_st[blk];
    logic [3:0] sb = 4'(1 << src);
    bit x_excl = 0, x_fwd = 0, x_fex = 0;
    int x_acks = 0;
    logic [3:0] x_inv = 0;
    int x_fdst = m_own[blk];
    string tg = "R3";
    int n_st = m_st[blk];
    logic [3:0] n_sh = m_sh[blk];
    int n_own = m_own[blk];
    int g_rsp = 0, g_fwd = 0, n_inv = 0, last = -1, waitc = 0;
    logic [3:0] seen = 0;
    logic [7:0] r_data = 0;
    int r_acks = 0, r_dst = 0, f_dst = 0, f_req = 0, f_blk = 0, r_blk = 0;
    bit r_excl = 0, r_op = 0, f_ex = 0;

    if (st == 0) begin
      tg = "R2"; x_excl = 1; n_st = ex ? 3 : 2; n_sh = sb; n_own = src;
    end else if (st == 1) begin
      if (!ex) begin
        tg = "R3"; n_sh = m_sh[blk] | sb;
      end else begin
        tg = "R6"; x_inv = m_sh[blk] & ~sb; x_acks = ones(x_inv);
        x_excl = 1; n_st = 3; n_sh = sb; n_own = src;
      end
    end else if (m_own[blk] == src) begin
      tg = "R9"; x_excl = 1; if (ex) n_st = 3;
    end else begin
      x_fwd = 1; x_fex = ex;
      if (ex) begin
        tg = "R8"; x_excl = 1; n_st = 3; n_sh = sb; n_own = src;
      end else begin
        tg = "R4"; n_st = 1; n_sh = sb | 4'(1 << m_own[blk]);
      end
    end

    @(negedge clk);
    req_valid = 1; req_excl = ex; req_src = 2'(src); req_blk = 2'(blk);
    #1;
    while (!req_ready && waitc < 20) begin
      @(negedge clk); #1; waitc++;
    end
    check(req_ready == 1, "R7", "ready on idle block", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;

    for (int c = 0; c < 16; c++) begin
      if (c == 0) begin
        check(rsp_valid == 1, "R10", "reply one cycle after accept", int'(rsp_valid), 1);
        check(fwd_valid == x_fwd, tg, "forward alongside reply", int'(fwd_valid), int'(x_fwd));
      end
      rsp_ready = (c >= 8) || ($urandom % 4 != 0);
      fwd_ready = (c >= 8) || ($urandom % 4 != 0);
      inv_ready = (c >= 8) || ($urandom % 4 != 0);
      if (rsp_valid && rsp_ready) begin
        g_rsp++; r_data = rsp_data; r_acks = int'(rsp_acks); r_excl = rsp_excl;
        r_op = rsp_owner_pending; r_dst = int'(rsp_dst); r_blk = int'(rsp_blk);
      end
      if (fwd_valid && fwd_ready) begin
        g_fwd++; f_dst = int'(fwd_dst); f_req = int'(fwd_req);
        f_ex = fwd_excl; f_blk = int'(fwd_blk);
      end
      if (inv_valid && inv_ready) begin
        check(int'(inv_dst) > last, "R10", "invalidation order", int'(inv_dst), last + 1);
        check(int'(inv_blk) == blk, "R6", "invalidation block", int'(inv_blk), blk);
        last = int'(inv_dst); seen[inv_dst] = 1'b1; n_inv++;
      end
      @(negedge clk);
    end
    rsp_ready = 0; fwd_ready = 0; inv_ready = 0;

    last_data = r_data;
    check(g_rsp == 1, tg, "reply count", g_rsp, 1);
    check(r_data == m_dat[blk], tg, "reply data", int'(r_data), int'(m_dat[blk]));
    check(r_dst == src && r_blk == blk, tg, "reply routing", r_dst * 4 + r_blk, src * 4 + blk);
    check(r_excl == x_excl, tg, "reply exclusive flag", int'(r_excl), int'(x_excl));
    check(r_op == x_fwd, tg, "owner pending flag", int'(r_op), int'(x_fwd));
    check(r_acks == x_acks, tg, "ack count", r_acks, x_acks);
    check(g_fwd == int'(x_fwd), tg, "forward count", g_fwd, int'(x_fwd));
    if (x_fwd) begin
      check(f_dst == x_fdst, tg, "forward target", f_dst, x_fdst);
      check(f_req == src && f_blk == blk, tg, "forward requester", f_req * 4 + f_blk, src * 4 + blk);
      check(f_ex == x_fex, tg, "forward exclusive flag", int'(f_ex), int'(x_fex));
    end
    check(seen == x_inv && n_inv == x_acks, tg, "invalidation set", int'(seen), int'(x_inv));

    if (x_acks > 0) begin
      int sent = 0;
      for (int i = 0; i < 4; i++) begin
        if (x_inv[i]) begin
          if (probe && sent == x_acks - 1) probe_stall(blk);
          send_cin(2'd0, blk, 8'h00);
          sent++;
        end
      end
      #1;
      check(req_ready == 1, "R7", "ready after last ack", int'(req_ready), 1);
    end
    if (x_fwd) begin
      if (probe) probe_stall(blk);
      send_cin(dirty ? 2'd2 : 2'd1, blk, wdat);
      #1;
      check(req_ready == 1, "R7", "ready after owner reply", int'(req_ready), 1);
      if (dirty) m_dat[blk] = wdat;
    end

    m_st[blk] = n_st; m_sh[blk] = n_sh; m_own[blk] = n_own;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin
      m_st[b] = 0; m_sh[b] = 0; m_own[b] = 0; m_dat[b] = seed_of(b);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(req_ready == 1, "R1", "ready after reset", int'(req_ready), 1);
    check(!rsp_valid && !inv_valid && !fwd_valid, "R1", "no message after reset",
          int'(rsp_valid) + int'(inv_valid) + int'(fwd_valid), 0);

    txn(0, 0, 0, 0, 0, 8'h00);                 // grant to invalid block
    check(last_data == seed_of(0), "R1", "reset data of block 0", int'(last_data), int'(seed_of(0)));
    txn(0, 0, 0, 0, 0, 8'h00);                 // owner re-read
    txn(0, 1, 0, 1, 1, 8'h3C);                 // forwarded read, dirty owner
    txn(0, 2, 0, 0, 0, 8'h00);                 // shared read
    check(last_data == 8'h3C, "R5", "dirty writeback reaches bank", int'(last_data), 8'h3C);
    txn(1, 2, 0, 0, 1, 8'h00);                 // invalidate sharers 0 and 1
    txn(1, 3, 0, 0, 1, 8'h99);                 // forwarded read-exclusive, clean owner
    txn(0, 1, 0, 0, 0, 8'h00);
    check(last_data == 8'h3C, "R5", "clean reply keeps bank", int'(last_data), 8'h3C);
    txn(1, 3, 3, 0, 0, 8'h00);
    txn(1, 3, 3, 0, 0, 8'h00);                 // owner read-exclusive

    send_cin(2'd2, 1, 8'h77);                  // stray writeback
    txn(0, 1, 1, 0, 0, 8'h00);
    check(last_data == seed_of(1), "R11", "stray writeback ignored", int'(last_data), int'(seed_of(1)));

    for (int t = 0; t < 300; t++) begin
      txn(1'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
          1'($urandom % 2), ($urandom % 4) == 0, 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule